// File: doc/BRIEF.md
# Custom Instruction Dispatch Controller

This controller sits between a processor's decode stage and a reconfigurable functional matrix. The decoder flags a dedicated invoke instruction, which is a move to coprocessor. The operand of that instruction is a custom instruction identifier. The controller uses the identifier to select an entry in a small configuration store. From that entry it takes four things:

- a cycle count;
- the register read enables and read addresses;
- the number of results and a destination register for each result;
- the resume address.

The count is loaded into a single down-counter. While the counter is non-zero, the block does three things. It drives the register-file read ports from the entry. It switches the register-file write ports from the ALU results to the matrix results. It also holds the pipeline in stall. The same busy condition controls both the selection and the stall. When the run finishes, the block hands the ports back to the decoder. In that final cycle it also asks the processor to load its program counter with the resume address, which is the instruction after the collapsed sequence.

The register file gives the matrix four write ports. An instruction with up to four results writes all of them in the last counted cycle. An instruction with five or six results writes the first four in that cycle. The remaining results are parked in two holding registers at the same clock edge and written in one extra cycle. While an instruction runs, the stall blocks any further invoke. The configuration store is filled through a write port after fabrication.

Top module: `ci_dispatch`

## Requirements
- R1: While no run is active, `stall`, `mtx_sel` and `pc_load` are 0. Every register-file read and write signal equals the matching decoder or ALU input.
- R2: An invoke seen while idle is accepted in that cycle. In the same cycle `mtx_cfg_load` is 1 and `mtx_cfg_id` equals `dec_ci_id`. `stall` is 1 in the next cycle.
- R3: For an entry with cycle count N ≥ 1 and at most four results, `stall` and `mtx_sel` stay 1 for exactly N cycles after acceptance. During those cycles `rf_re` and `rf_raddr` carry the entry's read mask and read addresses.
- R4: A stored cycle count of 0 runs for one cycle, the same as a count of 1.
- R5: In the last counted cycle, write port p (p = 0..3) is enabled exactly when p is less than the result count. An enabled port p carries destination slot p and matrix result slot p. Matrix result slot j sits at bits [16j+15:16j] of `mtx_res`. Destination slot j sits at bits [4j+3:4j] of the entry's destination field. Write ports are disabled in all other busy cycles.
- R6: With a result count of 5 or 6, the run lasts N+1 cycles. In the extra cycle, port p (p = 0..1) is enabled exactly when p+4 is less than the result count. An enabled port p writes destination slot p+4 with the value that result slot p+4 had in the last counted cycle.
- R7: `pc_load` is 1 only in the final busy cycle of a run, and `pc_target` then holds the entry's resume address. A run ends only through that cycle.
- R8: An invoke that arrives while a run is active is ignored. It produces no `mtx_cfg_load` pulse, and the run's length and outputs stay unchanged.
- R9: A configuration write takes effect on the next invoke of that entry. A write made during a run does not alter the run in progress.
- R10: During and directly after reset, `stall`, `mtx_sel` and `pc_load` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_invoke | input | 1 | Decoder sees the invoke instruction |
| dec_ci_id | input | 3 | Custom instruction identifier from the invoke operand |
| dec_re | input | 4 | Decoder read-port enables |
| dec_raddr | input | 16 | Decoder read addresses, 4 bits per port |
| dec_we | input | 4 | Decoder write-port enables |
| dec_waddr | input | 16 | Decoder write addresses, 4 bits per port |
| alu_wdata | input | 64 | ALU write data, 16 bits per port |
| mtx_res | input | 96 | Matrix results, six 16-bit slots |
| cfg_we | input | 1 | Configuration entry write strobe |
| cfg_idx | input | 3 | Entry being written |
| cfg_cycles | input | 4 | Cycle count of the entry |
| cfg_rmask | input | 4 | Read enable mask of the entry |
| cfg_raddr | input | 16 | Read addresses of the entry |
| cfg_nout | input | 3 | Result count of the entry (0..6) |
| cfg_waddr | input | 24 | Destination slots of the entry, 4 bits each |
| cfg_resume | input | 16 | Resume address of the entry |
| rf_re | output | 4 | Register-file read enables |
| rf_raddr | output | 16 | Register-file read addresses |
| rf_we | output | 4 | Register-file write enables |
| rf_waddr | output | 16 | Register-file write addresses |
| rf_wdata | output | 64 | Register-file write data |
| mtx_sel | output | 1 | Matrix results selected |
| mtx_cfg_load | output | 1 | Matrix configuration load strobe |
| mtx_cfg_id | output | 3 | Configuration entry for the matrix |
| stall | output | 1 | Pipeline stall |
| pc_load | output | 1 | Load the program counter |
| pc_target | output | 16 | Resume address |

## Verification
On every cycle, the assertions check the following:

- write pass-through while idle;
- that an acceptance is followed by a stall;
- that no acceptance happens during a stall;
- that a run ends only through a single `pc_load` cycle.

The bench scenarios are the only way to show the quantitative behaviour. That covers the exact run length for each cycle count, including the zero-count case. It also covers which write ports fire in the last counted cycle and in the extra cycle, and the destination and data each port carries. Finally, they show that held overflow results keep last-cycle values, and that a rewrite of the configuration during a run is ignored.

// File: rtl/ci_pkg.sv
package ci_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RUN  = 2'd1,
    PH_XTRA = 2'd2
  } ci_phase_e;
endpackage

// File: rtl/ci_cfg_mem.sv
module ci_cfg_mem #(
  parameter int IDX_W = 3,
  parameter int ENT_W = 67
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [ENT_W-1:0] wr_ent,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [ENT_W-1:0] rd_ent
);
  localparam int DEPTH = 1 << IDX_W;

  logic [ENT_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_idx] <= wr_ent;
  end

  assign rd_ent = mem_q[rd_idx];
endmodule

// File: rtl/ci_seq.sv
module ci_seq
  import ci_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int NO_W  = 3,
  parameter int LAT_W = 63,
  parameter int NWP   = 4,
  parameter int HLD_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [CNT_W-1:0] ld_cycles,
  input  logic [NO_W-1:0]  ld_nout,
  input  logic [LAT_W-1:0] ent_in,
  input  logic [HLD_W-1:0] hold_in,
  output ci_phase_e        phase,
  output logic             last_run,
  output logic             need_x,
  output logic [LAT_W-1:0] ent_q,
  output logic [HLD_W-1:0] hold_q
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             xtra_q, xtra_d;
  logic             needx_q, needx_d;
  logic             ent_en, hold_en;

  always_comb begin
    cnt_d   = cnt_q;
    xtra_d  = xtra_q;
    needx_d = needx_q;
    ent_en  = 1'b0;
    hold_en = 1'b0;
    if (xtra_q) begin
      xtra_d = 1'b0;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1) && needx_q) begin
        xtra_d  = 1'b1;
        hold_en = 1'b1;
      end
    end else if (accept) begin
      cnt_d   = (ld_cycles == '0) ? CNT_W'(1) : ld_cycles;
      needx_d = (ld_nout > NO_W'(NWP));
      ent_en  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      xtra_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      xtra_q <= xtra_d;
    end
  end

  always_ff @(posedge clk) begin
    if (ent_en) begin
      ent_q   <= ent_in;
      needx_q <= needx_d;
    end
    if (hold_en) hold_q <= hold_in;
  end

  always_comb begin
    if (xtra_q)            phase = PH_XTRA;
    else if (cnt_q != '0)  phase = PH_RUN;
    else                   phase = PH_IDLE;
  end

  assign last_run = (cnt_q == CNT_W'(1)) && !xtra_q;
  assign need_x   = needx_q;
endmodule

// File: rtl/ci_wport_mux.sv
module ci_wport_mux #(
  parameter int DW   = 16,
  parameter int RA_W = 4
) (
  input  logic            busy,
  input  logic            xtra,
  input  logic            dec_we,
  input  logic [RA_W-1:0] dec_addr,
  input  logic [DW-1:0]   alu_data,
  input  logic            m_we,
  input  logic [RA_W-1:0] m_addr,
  input  logic [DW-1:0]   m_data,
  input  logic            x_we,
  input  logic [RA_W-1:0] x_addr,
  input  logic [DW-1:0]   x_data,
  output logic            we,
  output logic [RA_W-1:0] addr,
  output logic [DW-1:0]   data
);
  always_comb begin
    if (!busy) begin
      we = dec_we;   addr = dec_addr; data = alu_data;
    end else if (xtra) begin
      we = x_we;     addr = x_addr;   data = x_data;
    end else begin
      we = m_we;     addr = m_addr;   data = m_data;
    end
  end
endmodule

// File: rtl/ci_dispatch.sv
module ci_dispatch
  import ci_pkg::*;
#(
  parameter int DW    = 16,
  parameter int RA_W  = 4,
  parameter int NRP   = 4,
  parameter int NWP   = 4,
  parameter int NHOLD = 2,
  parameter int IDX_W = 3,
  parameter int CNT_W = 4,
  parameter int PC_W  = 16,
  localparam int NRES = NWP + NHOLD,
  localparam int NO_W = $clog2(NRES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 dec_invoke,
  input  logic [IDX_W-1:0]     dec_ci_id,
  input  logic [NRP-1:0]       dec_re,
  input  logic [NRP*RA_W-1:0]  dec_raddr,
  input  logic [NWP-1:0]       dec_we,
  input  logic [NWP*RA_W-1:0]  dec_waddr,
  input  logic [NWP*DW-1:0]    alu_wdata,
  input  logic [NRES*DW-1:0]   mtx_res,
  input  logic                 cfg_we,
  input  logic [IDX_W-1:0]     cfg_idx,
  input  logic [CNT_W-1:0]     cfg_cycles,
  input  logic [NRP-1:0]       cfg_rmask,
  input  logic [NRP*RA_W-1:0]  cfg_raddr,
  input  logic [NO_W-1:0]      cfg_nout,
  input  logic [NRES*RA_W-1:0] cfg_waddr,
  input  logic [PC_W-1:0]      cfg_resume,
  output logic [NRP-1:0]       rf_re,
  output logic [NRP*RA_W-1:0]  rf_raddr,
  output logic [NWP-1:0]       rf_we,
  output logic [NWP*RA_W-1:0]  rf_waddr,
  output logic [NWP*DW-1:0]    rf_wdata,
  output logic                 mtx_sel,
  output logic                 mtx_cfg_load,
  output logic [IDX_W-1:0]     mtx_cfg_id,
  output logic                 stall,
  output logic                 pc_load,
  output logic [PC_W-1:0]      pc_target
);
  localparam int O_RM  = 0;
  localparam int O_RA  = O_RM + NRP;
  localparam int O_NO  = O_RA + NRP * RA_W;
  localparam int O_WA  = O_NO + NO_W;
  localparam int O_PC  = O_WA + NRES * RA_W;
  localparam int LAT_W = O_PC + PC_W;
  localparam int ENT_W = CNT_W + LAT_W;
  localparam int HLD_W = NHOLD * DW;

  logic [1:0] rs_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  logic [ENT_W-1:0] wr_ent, rd_ent;
  logic [LAT_W-1:0] ent_q;
  logic [HLD_W-1:0] hold_q;
  ci_phase_e        phase;
  logic             last_run, need_x, busy, xtra, accept;
  logic [NO_W-1:0]  nout_q;

  assign wr_ent = {cfg_resume, cfg_waddr, cfg_nout, cfg_raddr, cfg_rmask, cfg_cycles};

  ci_cfg_mem #(.IDX_W(IDX_W), .ENT_W(ENT_W)) u_mem (
    .clk(clk), .wr_en(cfg_we), .wr_idx(cfg_idx), .wr_ent(wr_ent),
    .rd_idx(dec_ci_id), .rd_ent(rd_ent)
  );

  assign busy   = (phase != PH_IDLE);
  assign xtra   = (phase == PH_XTRA);
  assign accept = dec_invoke && !busy;

  ci_seq #(.CNT_W(CNT_W), .NO_W(NO_W), .LAT_W(LAT_W), .NWP(NWP), .HLD_W(HLD_W)) u_seq (
    .clk(clk), .rst_n(rst_i_n), .accept(accept),
    .ld_cycles(rd_ent[CNT_W-1:0]),
    .ld_nout(rd_ent[CNT_W+O_NO +: NO_W]),
    .ent_in(rd_ent[ENT_W-1:CNT_W]),
    .hold_in(mtx_res[NRES*DW-1:NWP*DW]),
    .phase(phase), .last_run(last_run), .need_x(need_x),
    .ent_q(ent_q), .hold_q(hold_q)
  );

  assign nout_q = ent_q[O_NO +: NO_W];

  genvar p;
  generate
    for (p = 0; p < NWP; p++) begin : g_wp
      logic            m_we, x_we;
      logic [RA_W-1:0] x_addr;
      logic [DW-1:0]   x_data;
      assign m_we = last_run && (NO_W'(p) < nout_q);
      if (p < NHOLD) begin : g_hold
        assign x_we   = (NO_W'(p + NWP) < nout_q);
        assign x_addr = ent_q[O_WA + (p + NWP) * RA_W +: RA_W];
        assign x_data = hold_q[p*DW +: DW];
      end else begin : g_nohold
        assign x_we   = 1'b0;
        assign x_addr = '0;
        assign x_data = '0;
      end
      ci_wport_mux #(.DW(DW), .RA_W(RA_W)) u_mux (
        .busy(busy), .xtra(xtra),
        .dec_we(dec_we[p]), .dec_addr(dec_waddr[p*RA_W +: RA_W]),
        .alu_data(alu_wdata[p*DW +: DW]),
        .m_we(m_we), .m_addr(ent_q[O_WA + p*RA_W +: RA_W]),
        .m_data(mtx_res[p*DW +: DW]),
        .x_we(x_we), .x_addr(x_addr), .x_data(x_data),
        .we(rf_we[p]), .addr(rf_waddr[p*RA_W +: RA_W]), .data(rf_wdata[p*DW +: DW])
      );
    end
  endgenerate

  assign rf_re        = busy ? ent_q[O_RM +: NRP] : dec_re;
  assign rf_raddr     = busy ? ent_q[O_RA +: NRP*RA_W] : dec_raddr;
  assign mtx_sel      = busy;
  assign stall        = busy;
  assign mtx_cfg_load = accept;
  assign mtx_cfg_id   = dec_ci_id;
  assign pc_load      = xtra || (last_run && !need_x);
  assign pc_target    = ent_q[O_PC +: PC_W];
endmodule

// File: rtl/ci_dispatch_chk.sv
module ci_dispatch_chk #(
  parameter int NWP = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NWP-1:0] dec_we,
  input logic [NWP-1:0] rf_we,
  input logic           stall,
  input logic           pc_load,
  input logic           mtx_cfg_load
);
  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !stall |-> (rf_we == dec_we)); // R1
  AST_ACCEPT_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    mtx_cfg_load |=> stall); // R2
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !mtx_cfg_load); // R8
  AST_PC_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> stall); // R7
  AST_PC_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> !stall); // R7
  AST_RUN_NEEDS_PC: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !pc_load) |=> stall); // R7
endmodule

bind ci_dispatch ci_dispatch_chk #(.NWP(NWP)) u_chk (
  .clk(clk), .rst_n(rst_n), .dec_we(dec_we), .rf_we(rf_we),
  .stall(stall), .pc_load(pc_load), .mtx_cfg_load(mtx_cfg_load)
);

// File: tb/tb_ci_dispatch.sv
`timescale 1ns/1ps
module tb_ci_dispatch;
  logic        clk, rst_n;
  logic        dec_invoke;
  logic [2:0]  dec_ci_id;
  logic [3:0]  dec_re, dec_we;
  logic [15:0] dec_raddr, dec_waddr;
  logic [63:0] alu_wdata;
  logic [95:0] mtx_res;
  logic        cfg_we;
  logic [2:0]  cfg_idx;
  logic [3:0]  cfg_cycles, cfg_rmask;
  logic [15:0] cfg_raddr;
  logic [2:0]  cfg_nout;
  logic [23:0] cfg_waddr;
  logic [15:0] cfg_resume;
  logic [3:0]  rf_re, rf_we;
  logic [15:0] rf_raddr, rf_waddr;
  logic [63:0] rf_wdata;
  logic        mtx_sel, mtx_cfg_load, stall, pc_load;
  logic [2:0]  mtx_cfg_id;
  logic [15:0] pc_target;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  ci_dispatch dut (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(int ncyc, int k, int j);
    return 16'(k * 256 + j * 16 + ncyc + 1);
  endfunction

  function automatic logic [3:0] wslot(int ncyc, int nout, int j);
    return 4'(ncyc + 2 * j + nout + 1);
  endfunction

  task automatic run_ci(input int ncyc, input int nout);
    int id, n, total;
    logic [3:0]  rmask, ewe;
    logic [15:0] raddr, resume, ewa;
    logic [63:0] ewd;
    id     = (ncyc * 3 + nout) % 8;
    n      = (ncyc == 0) ? 1 : ncyc;
    total  = n + ((nout > 4) ? 1 : 0);
    rmask  = 4'(ncyc * 5 + nout + 1);
    resume = 16'(16'h4000 + ncyc * 32 + nout);
    for (int i = 0; i < 4; i++) raddr[i*4 +: 4] = 4'(id + 3 * i);
    // R9: entry written before invoke
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'(id); cfg_cycles = 4'(ncyc); cfg_rmask = rmask;
    cfg_raddr = raddr; cfg_nout = 3'(nout); cfg_resume = resume;
    for (int j = 0; j < 6; j++) cfg_waddr[j*4 +: 4] = wslot(ncyc, nout, j);
    dec_invoke = 1'b0;
    @(negedge clk);
    cfg_we = 1'b0;
    dec_invoke = 1'b1; dec_ci_id = 3'(id);
    dec_re = 4'(ncyc); dec_we = 4'(nout + 3); dec_raddr = 16'(ncyc * 77);
    dec_waddr = 16'(nout * 91); alu_wdata = {4{16'(ncyc * 13 + nout)}};
    #1;
    chk("R2 cfg_load", 64'(mtx_cfg_load), 64'd1);
    chk("R2 cfg_id", 64'(mtx_cfg_id), 64'(id));
    chk("R1 idle stall", 64'(stall), 64'd0);
    chk("R1 idle we", 64'(rf_we), 64'(dec_we));
    for (int k = 0; k < total; k++) begin
      @(negedge clk);
      if (k == 0) begin
        dec_ci_id = 3'(id + 1);          // R8: second invoke during run
        cfg_we = 1'b1; cfg_idx = 3'(id); // R9: rewrite during run
        cfg_cycles = 4'd15; cfg_nout = 3'd6; cfg_rmask = ~rmask;
        cfg_resume = 16'hdead; cfg_waddr = '1;
      end else begin
        dec_invoke = 1'b0; cfg_we = 1'b0;
      end
      for (int j = 0; j < 6; j++) mtx_res[j*16 +: 16] = pat(ncyc, k, j);
      #1;
      ewe = '0; ewa = '0; ewd = '0;
      for (int p = 0; p < 4; p++) begin
        if (k == n - 1 && p < nout) begin
          ewe[p] = 1'b1; ewa[p*4 +: 4] = wslot(ncyc, nout, p);
          ewd[p*16 +: 16] = pat(ncyc, n - 1, p);
        end
        if (k == n && p + 4 < nout) begin
          ewe[p] = 1'b1; ewa[p*4 +: 4] = wslot(ncyc, nout, p + 4);
          ewd[p*16 +: 16] = pat(ncyc, n - 1, p + 4);
        end
      end
      chk("R3 R4 stall", 64'(stall), 64'd1);
      chk("R3 mtx_sel", 64'(mtx_sel), 64'd1);
      chk("R8 no accept", 64'(mtx_cfg_load), 64'd0);
      chk("R3 R9 rf_re", 64'(rf_re), 64'(rmask));
      chk("R3 rf_raddr", 64'(rf_raddr), 64'(raddr));
      chk((k == n) ? "R6 we" : "R5 we", 64'(rf_we), 64'(ewe));
      for (int p = 0; p < 4; p++) begin
        if (ewe[p]) begin
          chk((k == n) ? "R6 waddr" : "R5 waddr", 64'(rf_waddr[p*4 +: 4]), 64'(ewa[p*4 +: 4]));
          chk((k == n) ? "R6 wdata" : "R5 wdata", 64'(rf_wdata[p*16 +: 16]), 64'(ewd[p*16 +: 16]));
        end
      end
      chk("R7 pc_load", 64'(pc_load), 64'(k == total - 1));
      if (k == total - 1) chk("R7 pc_target", 64'(pc_target), 64'(resume));
    end
    @(negedge clk);
    dec_invoke = 1'b0; cfg_we = 1'b0;
    #1;
    chk("R3 R6 run end", 64'(stall), 64'd0);
    chk("R1 pc_load idle", 64'(pc_load), 64'd0);
    chk("R1 wdata", rf_wdata, alu_wdata);
    chk("R1 raddr", 64'(rf_raddr), 64'(dec_raddr));
  endtask

  initial begin
    rst_n = 1'b1; dec_invoke = 1'b0; dec_ci_id = '0; dec_re = '0; dec_we = '0;
    dec_raddr = '0; dec_waddr = '0; alu_wdata = '0; mtx_res = '0; cfg_we = 1'b0;
    cfg_idx = '0; cfg_cycles = '0; cfg_rmask = '0; cfg_raddr = '0; cfg_nout = '0;
    cfg_waddr = '0; cfg_resume = '0;
    #2 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R10 stall in reset", 64'(stall), 64'd0);
    chk("R10 pc_load in reset", 64'(pc_load), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk("R10 stall after reset", 64'(stall), 64'd0);
    chk("R10 mtx_sel after reset", 64'(mtx_sel), 64'd0);
    for (int c = 0; c < 10; c++)
      for (int o = 0; o <= 6; o++)
        run_ci(c, o);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule